// File: doc/BRIEF.md
# Wakeup Edge Recorder

This block sits between a set of external interrupt lines and a parent interrupt controller that may be powered off. When software arms it by setting both the enable bit and the edge-recording bit, it watches every line that is unmasked and configured as edge-sensitive. An active edge on such a line sets a pending bit for that line. The rising or falling edge is chosen per line. Each input first passes through a two-flop synchronizer.

On wake, software writes the flush bit of the control register. In the next cycle, the block drives a one-cycle pulse on the output of every line whose pending bit was set, and it clears those bits. Software then disarms the block. Before sleep, software normally acknowledges stale pending bits and then arms the block.

The mask, sensitivity and polarity bits are each changed through a pair of registers: one sets bits when ones are written to it, and the other clears bits when ones are written to it. All per-line bits are packed 32 to a word, and line n is at word offset (n/32)*4, bit n mod 32.

Top module: `wake_irq_recorder`

## Requirements
- R1: After reset, every line is masked (mask=1), level-sensitive (sens=0) and falling-polarity (pol=0). The block is disarmed, nothing is pending, every output is low, and the control register reads 0.
- R2: Writes to the register pairs behave as follows. Mask set is at 0x0C0 and mask clear at 0x100. Sensitivity set is at 0x180 and sensitivity clear at 0x1C0. Polarity set is at 0x240 and polarity clear at 0x280. A one bit sets or clears that line's bit, and a zero bit leaves it unchanged. Reading a set address returns the current state. Line n maps to address base+(n/32)*4, bit n mod 32.
- R3: When control bit 0 (enable) and bit 1 (edge mode) are both 1, an active edge on a line with mask=0 and sens=1 sets that line's pending bit. The active edge is rising when pol=1 and falling when pol=0. The bit is set on the third rising clock edge after the input changes, and it reads back at status address 0x000.
- R4: No pending bit is ever set on a line that is masked, on a line that is level-sensitive, on a line whose edge does not match its polarity, or on any line while enable or edge mode is 0.
- R5: Writing a one to a line's bit at acknowledge address 0x040 clears that line's pending bit. Zero bits have no effect.
- R6: A control write (address 0x300) with bit 2 set raises, in the following cycle only, irq_out for exactly the lines that were pending, and it clears those pending bits. At all other times irq_out is zero.
- R7: The flush bit is self-clearing and always reads 0. Control bits 0 and 1 read back as last written.
- R8: Reads of the clear addresses, the acknowledge address and unmapped addresses return 0. Read data appears on reg_rdata one cycle after reg_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NLINES | External interrupt lines (asynchronous) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| irq_out | output | NLINES | Replay pulses toward the parent controller |

## Verification
The bench runs random register writes and input toggles against a model of the register state. It targets edges that arrive on masked, level-sensitive or wrong-polarity lines, and edges that arrive while only one of the two arming bits is set. A design that gates on only one condition would show extra status bits. It checks that a flush pulses only the lines that were pending and only for one cycle; a design that left pending bits uncleared, or stretched the pulse, would fail there. It also covers lines in the upper word (at 0x004 offsets), zero-bit writes to the set, clear and acknowledge addresses, and readback of the flush bit. A wrong word index or a flush bit that stays at 1 is caught by these checks.

// File: rtl/wake_irq_recorder.sv
module wake_irq_recorder #(
  parameter int NLINES = 64,
  parameter int AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_in,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [AW-1:0]     reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [NLINES-1:0] irq_out
);
  localparam int NWORDS = (NLINES + 31) / 32;
  localparam logic [AW-1:0] A_STAT = AW'(12'h000);
  localparam logic [AW-1:0] A_ACK  = AW'(12'h040);
  localparam logic [AW-1:0] A_MSET = AW'(12'h0C0);
  localparam logic [AW-1:0] A_MCLR = AW'(12'h100);
  localparam logic [AW-1:0] A_SSET = AW'(12'h180);
  localparam logic [AW-1:0] A_SCLR = AW'(12'h1C0);
  localparam logic [AW-1:0] A_PSET = AW'(12'h240);
  localparam logic [AW-1:0] A_PCLR = AW'(12'h280);
  localparam logic [AW-1:0] A_CTRL = AW'(12'h300);

  function automatic logic [NLINES-1:0] wbits(input logic [AW-1:0] a,
                                              input logic [AW-1:0] base,
                                              input logic [31:0] d);
    logic [NLINES-1:0] r;
    r = '0;
    for (int i = 0; i < NLINES; i++)
      if (a == base + AW'(4 * (i / 32))) r[i] = d[i % 32];
    return r;
  endfunction

  function automatic logic [31:0] rword(input logic [AW-1:0] a,
                                       input logic [AW-1:0] base,
                                       input logic [NLINES-1:0] v);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < NLINES; i++)
      if (a == base + AW'(4 * (i / 32))) r[i % 32] = v[i];
    return r;
  endfunction

  logic [NLINES-1:0] mask, sens, pol, pending;
  logic [NLINES-1:0] s1, s2, s3;
  logic en, edge_mode;

  logic [NLINES-1:0] wd_ack, wd_mset, wd_mclr, wd_sset, wd_sclr, wd_pset, wd_pclr;
  assign wd_ack  = reg_wr ? wbits(reg_addr, A_ACK,  reg_wdata) : '0;
  assign wd_mset = reg_wr ? wbits(reg_addr, A_MSET, reg_wdata) : '0;
  assign wd_mclr = reg_wr ? wbits(reg_addr, A_MCLR, reg_wdata) : '0;
  assign wd_sset = reg_wr ? wbits(reg_addr, A_SSET, reg_wdata) : '0;
  assign wd_sclr = reg_wr ? wbits(reg_addr, A_SCLR, reg_wdata) : '0;
  assign wd_pset = reg_wr ? wbits(reg_addr, A_PSET, reg_wdata) : '0;
  assign wd_pclr = reg_wr ? wbits(reg_addr, A_PCLR, reg_wdata) : '0;

  logic ctrl_wr, flush_go, arm;
  assign ctrl_wr  = reg_wr && (reg_addr == A_CTRL);
  assign flush_go = ctrl_wr && reg_wdata[2];
  assign arm      = en && edge_mode;

  logic [NLINES-1:0] act, hit, clr;
  assign act = (s2 & ~s3 & pol) | (~s2 & s3 & ~pol);
  assign hit = {NLINES{arm}} & ~mask & sens & act;
  assign clr = wd_ack | {NLINES{flush_go}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
      mask <= '1;
      sens <= '0;
      pol <= '0;
      pending <= '0;
      en <= 1'b0;
      edge_mode <= 1'b0;
      irq_out <= '0;
    end else begin
      s1 <= irq_in;
      s2 <= s1;
      s3 <= s2;
      mask <= (mask | wd_mset) & ~wd_mclr;
      sens <= (sens | wd_sset) & ~wd_sclr;
      pol  <= (pol  | wd_pset) & ~wd_pclr;
      pending <= (pending & ~clr) | hit;
      irq_out <= flush_go ? pending : '0;
      if (ctrl_wr) begin
        en <= reg_wdata[0];
        edge_mode <= reg_wdata[1];
      end
    end
  end

  logic [31:0] rmux;
  assign rmux = rword(reg_addr, A_STAT, pending) | rword(reg_addr, A_MSET, mask)
              | rword(reg_addr, A_SSET, sens) | rword(reg_addr, A_PSET, pol)
              | ((reg_addr == A_CTRL) ? {30'd0, edge_mode, en} : 32'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rmux;
  end

  // R6
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out & ~$past(pending)) == '0);
  // R6
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_out) |-> $past(flush_go));
  // R4
  disarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> (pending & ~$past(pending)) == '0);
  // R4
  masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending & ~$past(pending) & ($past(mask) | ~$past(sens))) == '0);
  // R2
  mclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_MCLR && reg_wdata[0]) |=> !mask[0]);
endmodule

// File: tb/wake_irq_recorder_test.sv
module wake_irq_recorder_test;
  localparam int NL = 64;
  logic clk = 0, rst_n = 0;
  logic [NL-1:0] irq_in = '0;
  logic reg_wr = 0, reg_rd = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NL-1:0] irq_out;

  wake_irq_recorder #(.NLINES(NL), .AW(12)) uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out));

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  logic [NL-1:0] m_mask, m_sens, m_pol, m_pend;
  logic m_en, m_edge;

  function automatic logic [NL-1:0] sel(input logic [11:0] a, input logic [11:0] base,
                                        input logic [31:0] d);
    logic [NL-1:0] r = '0;
    for (int i = 0; i < NL; i++)
      if (a == base + 12'(4 * (i / 32))) r[i] = d[i % 32];
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
    m_mask = (m_mask | sel(a, 12'h0C0, d)) & ~sel(a, 12'h100, d);
    m_sens = (m_sens | sel(a, 12'h180, d)) & ~sel(a, 12'h1C0, d);
    m_pol  = (m_pol  | sel(a, 12'h240, d)) & ~sel(a, 12'h280, d);
    m_pend = m_pend & ~sel(a, 12'h040, d);
    if (a == 12'h300) begin m_en = d[0]; m_edge = d[1]; end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    reg_addr = a; reg_rd = 1;
    @(negedge clk);
    reg_rd = 0;
    v = reg_rdata;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] v;
    for (int w = 0; w < 2; w++) begin
      rd(12'h000 + 12'(4*w), v); check({tag, " R3 status"}, 64'(v), 64'(m_pend[32*w +: 32]));
      rd(12'h0C0 + 12'(4*w), v); check({tag, " R2 mask"},   64'(v), 64'(m_mask[32*w +: 32]));
      rd(12'h180 + 12'(4*w), v); check({tag, " R2 sens"},   64'(v), 64'(m_sens[32*w +: 32]));
      rd(12'h240 + 12'(4*w), v); check({tag, " R2 pol"},    64'(v), 64'(m_pol[32*w +: 32]));
    end
    rd(12'h300, v); check({tag, " R7 ctrl"}, 64'(v), {62'd0, m_edge, m_en});
  endtask

  task automatic toggle(input logic [NL-1:0] nv);
    logic [NL-1:0] old = irq_in, act;
    irq_in = nv;
    act = (nv & ~old & m_pol) | (~nv & old & ~m_pol);
    if (m_en && m_edge) m_pend = m_pend | (act & ~m_mask & m_sens);
    repeat (5) @(negedge clk);
  endtask

  task automatic flush(input logic [1:0] cb);
    logic [NL-1:0] exp = m_pend;
    reg_addr = 12'h300; reg_wdata = {29'd0, 1'b1, cb}; reg_wr = 1;
    check("R6 no early pulse", 64'(irq_out), 64'd0);
    @(negedge clk);
    reg_wr = 0;
    check("R6 pulse", 64'(irq_out), 64'(exp));
    @(negedge clk);
    check("R6 single cycle", 64'(irq_out), 64'd0);
    m_pend = '0; m_en = cb[0]; m_edge = cb[1];
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected<150000", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    m_mask = '1; m_sens = '0; m_pol = '0; m_pend = '0; m_en = 0; m_edge = 0;
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 outputs idle", 64'(irq_out), 64'd0);
    check_all("R1 reset");

    // R3 directed: line 5 rising, line 40 falling, upper word addressing
    wr(12'h0C0, 32'h0); wr(12'h100, 32'h20); wr(12'h104, 32'h100);
    wr(12'h180, 32'h20); wr(12'h184, 32'h100); wr(12'h240, 32'h20);
    wr(12'h300, 32'h3);
    irq_in[5] = 1; irq_in[40] = 1;
    repeat (3) @(negedge clk);
    rd(12'h000, v); check("R3 rising at third edge", 64'(v), 64'h20);
    rd(12'h004, v); check("R4 wrong polarity", 64'(v), 64'h0);
    m_pend[5] = 1;
    toggle(irq_in & ~(64'd1 << 40) & ~(64'd1 << 5));
    check_all("R3 falling");
    // R5 ack zero bits, then clear
    wr(12'h044, 32'h0); check_all("R5 zero ack");
    wr(12'h044, 32'h100); check_all("R5 ack");
    // R8 read-zero addresses
    rd(12'h100, v); check("R8 mask clear reads 0", 64'(v), 64'h0);
    rd(12'h040, v); check("R8 ack reads 0", 64'(v), 64'h0);
    rd(12'h3F0, v); check("R8 unmapped reads 0", 64'(v), 64'h0);
    // R4 only enable set
    wr(12'h300, 32'h1); toggle(irq_in ^ 64'h20); check_all("R4 half armed");
    wr(12'h300, 32'h3);
    flush(2'b11);
    rd(12'h300, v); check("R7 flush reads 0", 64'(v), 64'h3);

    for (int it = 0; it < 600; it++) begin
      int op = $urandom_range(0, 9);
      if (op < 4) begin
        logic [11:0] a;
        logic [31:0] d = $urandom();
        case ($urandom_range(0, 7))
          0: a = 12'h040; 1: a = 12'h0C0; 2: a = 12'h100; 3: a = 12'h180;
          4: a = 12'h1C0; 5: a = 12'h240; 6: a = 12'h280; default: a = 12'h300;
        endcase
        if (a != 12'h300) a = a + 12'(4 * $urandom_range(0, 1));
        else d = ($urandom_range(0, 9) < 7) ? 32'h3 : (d & 32'h3);
        wr(a, d);
      end else if (op < 8) begin
        toggle(irq_in ^ {$urandom(), $urandom()});
      end else if (op == 8) begin
        flush(($urandom_range(0, 3) == 0) ? 2'($urandom()) : 2'b11);
      end else begin
        check_all("R2 R3 R4 R5 random");
      end
    end
    check_all("R2 final");
    flush(2'b00);
    check_all("R6 after flush");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule